// File: doc/BRIEF.md
# BCD Calendar Date Counter

This block holds a calendar date as packed BCD: a two-digit day, a two-digit month and a four-digit year, eight digits in all, ready for a digit display. A time-of-day counter sends it a single-cycle pulse at each midnight, and the date moves forward by one day on that pulse. The last day of each month is worked out from the current month and from a leap-year test done directly on the four BCD year digits, so no conversion to binary is needed anywhere.

A synchronous load sets the whole date at once. A loaded day beyond the end of the loaded month is pulled back to that month's last day. A loaded day of zero becomes the first of the month. This keeps the day field valid whatever the setting source provides. The year counts through all four decades and wraps from 9999 back to 0000.

Top module: `date_keeper`

## Requirements
- R1: While reset is low and after its release, the date reads day 8'h01, month 8'h01, year 16'h2000 (the default reset parameters) until a tick or a load arrives.
- R2: A one-cycle `day_tick` that is not the last day of the month adds one to the BCD day on the next rising edge, carrying from the ones digit into the tens digit (09 becomes 10). Month and year stay unchanged.
- R3: Month length: 30 days for months 8'h04, 8'h06, 8'h09 and 8'h11; 28 or 29 days for 8'h02; 31 days for every other month. A tick on the last day sets the day to 8'h01 and moves the month on by one in BCD (8'h09 becomes 8'h10).
- R4: February has 29 days when the year is a leap year: divisible by 4 and not by 100, or divisible by 400 (so 2024, 2000, 1600 and 0000 are leap years; 2023, 1900 and 2100 are not).
- R5: A tick on day 8'h31 of month 8'h12 gives day 8'h01, month 8'h01 and the year plus one in BCD; year 16'h9999 goes to 16'h0000.
- R6: When `ld_en` is high, the next edge writes the loaded month and year and the (possibly clamped) day; a `day_tick` in the same cycle is dropped.
- R7: A loaded day greater than the loaded month's length is stored as that month's last day; a loaded day of 8'h00 is stored as 8'h01.
- R8: With neither `day_tick` nor `ld_en` high, the date holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| day_tick | input | 1 | One-cycle pulse: advance the date by one day |
| ld_en | input | 1 | Load the date from the `ld_*` inputs |
| ld_day | input | 8 | Day to load, two BCD digits |
| ld_mon | input | 8 | Month to load, two BCD digits (01 to 12) |
| ld_year | input | 16 | Year to load, four BCD digits, thousands in [15:12] |
| day_bcd | output | 8 | Current day, two BCD digits |
| mon_bcd | output | 8 | Current month, two BCD digits |
| year_bcd | output | 16 | Current year, four BCD digits |

## Verification
A wrong month length or leap decision shows up only on a tick issued on the 28th to 31st day. It then appears one edge later as a day of 01 where a 29, 30 or 31 was due, or as a day past the month's end. So the bench lands each month-end case by loading the date just before it and ticking once. A wrong carry in the year chain stays hidden until a December 31 rollover crosses a nine in some digit. The full-year walks and the 9999 case reach that rollover directly, and the year-step assertions report it on the edge after the step.

// File: rtl/cal_pkg.sv
package cal_pkg;

  // Add one to a two-digit BCD value (no wrap handling beyond 99).
  function automatic logic [7:0] bcd2_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Divisible by four, taken on two BCD digits: an even tens digit needs
  // ones in {0,4,8}; an odd tens digit needs ones in {2,6}.
  function automatic logic bcd2_div4(input logic [7:0] v);
    logic [3:0] ones;
    ones = v[3:0];
    if (!v[4]) return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
    else       return (ones == 4'd2) || (ones == 4'd6);
  endfunction

  // Leap test on four BCD digits. A nonzero low pair decides by itself;
  // a zero low pair means a century, decided by the high pair.
  function automatic logic bcd4_leap(input logic [15:0] y);
    if (y[7:0] != 8'h00) return bcd2_div4(y[7:0]);
    else                 return bcd2_div4(y[15:8]);
  endfunction

  // Last day of a BCD month.
  function automatic logic [7:0] bcd_last_day(input logic [7:0] m, input logic leap);
    logic [7:0] r;
    case (m)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cal_leap_detect.sv
module cal_leap_detect #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] year,
  output logic                leap
);
  import cal_pkg::*;
  localparam int YW = 4 * DIGITS;

  logic [15:0] y4;
  generate
    if (YW >= 16) begin : g_wide
      assign y4 = year[15:0];
    end else begin : g_narrow
      assign y4 = {{(16 - YW){1'b0}}, year};
    end
  endgenerate

  assign leap = bcd4_leap(y4);
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
  input  logic [7:0] mon,
  input  logic       leap,
  output logic [7:0] last_day
);
  import cal_pkg::*;
  assign last_day = bcd_last_day(mon, leap);
endmodule

// File: rtl/cal_year_counter.sv
module cal_year_counter #(
  parameter int              DIGITS    = 4,
  parameter logic [4*DIGITS-1:0] RESET_VAL = 16'h2000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [4*DIGITS-1:0] load_val,
  input  logic                step,
  output logic [4*DIGITS-1:0] year
);
  logic [DIGITS:0] carry;
  assign carry[0] = step;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      logic [3:0] q;
      assign carry[i+1] = carry[i] && (q == 4'd9);
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= RESET_VAL[4*i +: 4];
        else if (load)     q <= load_val[4*i +: 4];
        else if (carry[i]) q <= (q == 4'd9) ? 4'd0 : q + 4'd1;
      end
      assign year[4*i +: 4] = q;
    end
  endgenerate
endmodule

// File: rtl/date_keeper.sv
module date_keeper #(
  parameter int          YEAR_DIGITS = 4,
  parameter logic [7:0]  RESET_DAY   = 8'h01,
  parameter logic [7:0]  RESET_MON   = 8'h01,
  parameter logic [15:0] RESET_YEAR  = 16'h2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        day_tick,
  input  logic        ld_en,
  input  logic [7:0]  ld_day,
  input  logic [7:0]  ld_mon,
  input  logic [15:0] ld_year,
  output logic [7:0]  day_bcd,
  output logic [7:0]  mon_bcd,
  output logic [15:0] year_bcd
);
  import cal_pkg::*;
  localparam int YW = 4 * YEAR_DIGITS;

  logic [7:0] day_q, mon_q;
  logic       leap_now, leap_ld;
  logic [7:0] last_now, last_ld;
  logic [7:0] day_ld_fix;

  // Named internal events, used by the checker.
  logic day_wrap;   // tick lands on the month's last day
  logic mon_wrap;   // ... and the month is December
  logic year_step;  // year counter advances this edge

  cal_leap_detect #(.DIGITS(YEAR_DIGITS)) u_leap_now (.year(year_bcd), .leap(leap_now));
  cal_leap_detect #(.DIGITS(YEAR_DIGITS)) u_leap_ld  (.year(ld_year),  .leap(leap_ld));
  cal_month_len u_len_now (.mon(mon_q),  .leap(leap_now), .last_day(last_now));
  cal_month_len u_len_ld  (.mon(ld_mon), .leap(leap_ld),  .last_day(last_ld));

  assign day_wrap  = day_tick && (day_q == last_now);
  assign mon_wrap  = day_wrap && (mon_q == 8'h12);
  assign year_step = mon_wrap && !ld_en;

  always_comb begin
    if (ld_day == 8'h00)      day_ld_fix = 8'h01;
    else if (ld_day > last_ld) day_ld_fix = last_ld;
    else                       day_ld_fix = ld_day;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day_q <= RESET_DAY;
      mon_q <= RESET_MON;
    end else if (ld_en) begin
      day_q <= day_ld_fix;
      mon_q <= ld_mon;
    end else if (day_tick) begin
      if (day_wrap) begin
        day_q <= 8'h01;
        mon_q <= mon_wrap ? 8'h01 : bcd2_inc(mon_q);
      end else begin
        day_q <= bcd2_inc(day_q);
      end
    end
  end

  cal_year_counter #(.DIGITS(YEAR_DIGITS), .RESET_VAL(RESET_YEAR[YW-1:0])) u_year (
    .clk(clk), .rst_n(rst_n), .load(ld_en), .load_val(ld_year[YW-1:0]),
    .step(year_step), .year(year_bcd[YW-1:0])
  );

  generate
    if (YW < 16) begin : g_pad
      assign year_bcd[15:YW] = '0;
    end
  endgenerate

  assign day_bcd = day_q;
  assign mon_bcd = mon_q;
endmodule

// File: rtl/cal_chk.sv
module cal_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        day_tick,
  input logic        ld_en,
  input logic [7:0]  day_bcd,
  input logic [7:0]  mon_bcd,
  input logic [15:0] year_bcd,
  input logic        day_wrap,
  input logic        year_step
);
  // R2: an ordinary day step leaves month and year alone
  a_r2_day_only: assert property (@(posedge clk) disable iff (!rst_n)
    (day_tick && !ld_en && !day_wrap) |=> ($stable(mon_bcd) && $stable(year_bcd)));

  // R3: a month-end tick restarts the day at 01
  a_r3_wrap_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (day_tick && !ld_en && day_wrap) |=> (day_bcd == 8'h01));

  // R3: day never leaves 01..31, month never leaves 01..12
  a_r3_day_range: assert property (@(posedge clk) disable iff (!rst_n)
    (day_bcd != 8'h00) && (day_bcd <= 8'h31));
  a_r3_mon_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_bcd != 8'h00) && (mon_bcd <= 8'h12));

  // R5: the year moves only on a December 31 step or a load
  a_r5_year_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !year_step) |=> $stable(year_bcd));
  a_r5_year_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (year_step && year_bcd != 16'h9999) |=> (year_bcd != $past(year_bcd) && mon_bcd == 8'h01));
  a_r5_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (year_step && year_bcd == 16'h9999) |=> (year_bcd == 16'h0000));

  // R7: a loaded day is never zero
  a_r7_no_zero_day: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (day_bcd != 8'h00));

  // R8: idle cycles hold the date
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!day_tick && !ld_en) |=> ($stable(day_bcd) && $stable(mon_bcd)));
endmodule

bind date_keeper cal_chk u_chk (
  .clk(clk), .rst_n(rst_n), .day_tick(day_tick), .ld_en(ld_en),
  .day_bcd(day_bcd), .mon_bcd(mon_bcd), .year_bcd(year_bcd),
  .day_wrap(day_wrap), .year_step(year_step)
);

// File: tb/sim_date_keeper.sv
`timescale 1ns/1ps
module sim_date_keeper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic day_tick = 1'b0;
  logic ld_en = 1'b0;
  logic [7:0]  ld_day = 8'h00;
  logic [7:0]  ld_mon = 8'h00;
  logic [15:0] ld_year = 16'h0000;
  logic [7:0]  day_bcd, mon_bcd;
  logic [15:0] year_bcd;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  date_keeper u0 (
    .clk(clk), .rst_n(rst_n), .day_tick(day_tick), .ld_en(ld_en),
    .ld_day(ld_day), .ld_mon(ld_mon), .ld_year(ld_year),
    .day_bcd(day_bcd), .mon_bcd(mon_bcd), .year_bcd(year_bcd)
  );

  // {load day, load month, load year, expected day, month, year after one tick}
  localparam int NV = 18;
  localparam logic [63:0] VEC [NV] = '{
    64'h15_03_2024_16_03_2024,  // R2 plain step
    64'h09_01_2023_10_01_2023,  // R2 ones-to-tens carry
    64'h30_07_2020_31_07_2020,  // R3 31-day month not yet ended
    64'h30_04_2023_01_05_2023,  // R3 April 30
    64'h30_06_2021_01_07_2021,  // R3 June 30
    64'h30_09_2021_01_10_2021,  // R3 September 30, month 09 to 10
    64'h30_11_2021_01_12_2021,  // R3 November 30
    64'h31_01_2023_01_02_2023,  // R3 January 31
    64'h28_02_2023_01_03_2023,  // R4 plain year
    64'h28_02_2024_29_02_2024,  // R4 leap by four
    64'h29_02_2024_01_03_2024,  // R4 leap February end
    64'h28_02_2012_29_02_2012,  // R4 odd tens digit
    64'h28_02_1900_01_03_1900,  // R4 century not leap
    64'h28_02_2100_01_03_2100,  // R4 century not leap
    64'h28_02_2000_29_02_2000,  // R4 divisible by 400
    64'h28_02_1600_29_02_1600,  // R4 divisible by 400
    64'h31_12_2023_01_01_2024,  // R5 year step
    64'h31_12_9999_01_01_0000   // R5 year wrap
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load(input logic [7:0] d, input logic [7:0] m, input logic [15:0] y, input logic with_tick);
    @(negedge clk);
    ld_day = d; ld_mon = m; ld_year = y; ld_en = 1'b1; day_tick = with_tick;
    @(negedge clk);
    ld_en = 1'b0; day_tick = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    day_tick = 1'b1;
    @(negedge clk);
    day_tick = 1'b0;
  endtask

  function automatic logic [31:0] now();
    return {day_bcd, mon_bcd, year_bcd};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset held", now(), 32'h01_01_2000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", now(), 32'h01_01_2000);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i][63:56], VEC[i][55:48], VEC[i][47:32], 1'b0);
      check("R6 load", now(), VEC[i][63:32]);
      tick();
      check($sformatf("R2/R3/R4/R5 vector %0d", i), now(), VEC[i][31:0]);
    end

    // R7 clamping
    load(8'h31, 8'h02, 16'h2023, 1'b0);
    check("R7 clamp Feb plain", now(), 32'h28_02_2023);
    load(8'h30, 8'h02, 16'h2024, 1'b0);
    check("R7 clamp Feb leap", now(), 32'h29_02_2024);
    load(8'h31, 8'h04, 16'h2023, 1'b0);
    check("R7 clamp April", now(), 32'h30_04_2023);
    load(8'h00, 8'h05, 16'h2023, 1'b0);
    check("R7 zero day", now(), 32'h01_05_2023);

    // R6 load wins over a tick in the same cycle
    load(8'h10, 8'h05, 16'h2023, 1'b1);
    check("R6 load over tick", now(), 32'h10_05_2023);

    // R8 idle hold
    repeat (6) @(negedge clk);
    check("R8 idle hold", now(), 32'h10_05_2023);

    // R3/R4/R5 full years: 365 ticks in 2023, 366 in 2024
    load(8'h01, 8'h01, 16'h2023, 1'b0);
    for (int k = 0; k < 59; k++) tick();
    check("R3 day 60 of 2023", now(), 32'h01_03_2023);
    for (int k = 59; k < 365; k++) tick();
    check("R5 year walk 2023", now(), 32'h01_01_2024);
    for (int k = 0; k < 59; k++) tick();
    check("R4 day 60 of 2024", now(), 32'h29_02_2024);
    for (int k = 59; k < 366; k++) tick();
    check("R5 year walk 2024", now(), 32'h01_01_2025);

    // R1 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", now(), 32'h01_01_2000);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule